// File: doc/BRIEF.md
# Colour Palette Access Port

This block holds a 256-entry colour lookup table in which every entry is a red, green and blue triplet of 6-bit components. A processor reaches the table through a byte-wide register bus with four port selects: one port positions the write pointer, one positions the read pointer, and one shared data port moves the components one at a time in red, green, blue order. Written components are staged and reach the table together only when the third one arrives. A pixel pipeline uses a separate lookup port. It registers an 8-bit pixel index and returns the selected entry as 24-bit RGB, with each component widened from 6 to 8 bits.

A single two-bit component counter serves reads and writes on the data port alike. A small mode register records whether the pointer set most recently was the write pointer or the read pointer. Software reads it back through the read-pointer port select.

Top module: `palette_dac_port`

## Requirements
- R1: A bus write with select 0 loads the write pointer from the data byte, clears the component counter to 0 and sets the mode to 0.
- R2: A bus write with select 1 loads the read pointer from the data byte, clears the component counter to 0 and sets the mode to 3.
- R3: A bus write with select 2 stages the byte in the slot chosen by the component counter and advances the counter. When the counter is 2, the two staged components and the current byte are stored together as red, green and blue at the write pointer, the counter returns to 0 and the write pointer advances by one. The table entry keeps its old value until that third byte arrives.
- R4: A bus read with select 2 returns the component of the entry at the read pointer that the counter selects (0 red, 1 green, 2 blue) and advances the counter. After blue the counter returns to 0 and the read pointer advances by one.
- R5: Reads and writes on select 2 advance the same component counter, so a read placed between two written bytes uses up one component position of the write sequence.
- R6: A bus read with select 1 returns the mode value (0 or 3) in bits 1:0, with the upper bits zero. Reads with select 0 or 3 return 0.
- R7: Only bits 5:0 of a written data byte are kept. Component reads return zero in bits 7:6.
- R8: Both pointers wrap from 255 to 0 when they advance.
- R9: bus_rdata and pix_rgb are registered. bus_rdata changes only on the clock edge that takes a read. pix_rgb shows the entry selected by pix_idx one edge after pix_idx is presented: red in bits 23:16, green in 15:8, blue in 7:0. Each component v becomes {v, v[0], v[0]}.
- R10: When bus_wr and bus_rd are both high, only the write takes effect. The read moves neither the pointers nor the counter, and bus_rdata holds its value.
- R11: Reset clears both pointers, the counter, the mode, the staging slots, bus_rdata, the registered pixel index and every table entry.
- R12: A processor read and a pixel lookup may happen in the same cycle and do not disturb each other. A lookup of the entry that is being committed on the same edge returns the newly committed triplet.
- R13: A bus write with select 3 changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_sel | input | 2 | Port select: 0 write pointer, 1 read pointer / mode, 2 data, 3 unused |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Registered read data byte |
| pix_idx | input | 8 | Pixel index for the display lookup |
| pix_rgb | output | 24 | Expanded RGB of the registered pixel index |

## Verification
Two pairs of functions can land in the same cycle. The first is a processor component read together with a pixel lookup. The second is the third data byte committing an entry on the same edge that the pixel port registers that entry's index. The bench drives both pairs in one step, on different entries and on the same entry. The scoreboard expects the CPU byte from the table as it stood before the edge and the pixel colour from the table as it stands after the commit. A simultaneous write and read is also checked: bus_rdata must hold its value and the later reads must show that the pointers did not move.

// File: rtl/dac_pkg.sv
package dac_pkg;

    localparam int IDX_W   = 8;
    localparam int COMP_W  = 6;
    localparam int OUT_W   = 8;
    localparam int DATA_W  = 8;
    localparam int N_COMP  = 3;
    localparam int ENTRIES = 1 << IDX_W;
    localparam int SUB_W   = 2;
    localparam int LAST_SUB = N_COMP - 1;

    typedef enum logic [1:0] {
        SEL_WIDX = 2'd0,
        SEL_RIDX = 2'd1,
        SEL_DATA = 2'd2,
        SEL_NONE = 2'd3
    } port_sel_e;

    typedef enum logic [1:0] {
        MODE_WRITING = 2'd0,
        MODE_READING = 2'd3
    } dac_mode_e;

    // component 0 is red, 1 green, 2 blue
    typedef logic [N_COMP-1:0][COMP_W-1:0] pal_entry_t;

    typedef struct packed {
        logic                wr;
        logic                rd;
        port_sel_e           sel;
        logic [DATA_W-1:0]   data;
    } bus_req_t;

    function automatic logic [OUT_W-1:0] widen(input logic [COMP_W-1:0] v);
        return {v, {(OUT_W-COMP_W){v[0]}}};
    endfunction

endpackage

// File: rtl/dac_index_ctrl.sv
module dac_index_ctrl
    import dac_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  bus_req_t         req,
    output logic [IDX_W-1:0] wptr,
    output logic [IDX_W-1:0] rptr,
    output logic [SUB_W-1:0] sub,
    output dac_mode_e        mode,
    output logic             commit,
    output logic [IDX_W-1:0] commit_idx,
    output pal_entry_t       commit_entry
);

    logic [COMP_W-1:0] stage_q [N_COMP-1];
    logic              wr_go;
    logic              rd_go;
    logic              last_slot;

    assign wr_go     = req.wr;
    assign rd_go     = req.rd && !req.wr;
    assign last_slot = (sub == SUB_W'(LAST_SUB));

    assign commit     = wr_go && (req.sel == SEL_DATA) && last_slot;
    assign commit_idx = wptr;

    always_comb begin
        commit_entry = '0;
        for (int c = 0; c < N_COMP - 1; c++) begin
            commit_entry[c] = stage_q[c];
        end
        commit_entry[N_COMP-1] = req.data[COMP_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr <= '0;
            rptr <= '0;
            sub  <= '0;
            mode <= MODE_WRITING;
            for (int c = 0; c < N_COMP - 1; c++) begin
                stage_q[c] <= '0;
            end
        end else if (wr_go) begin
            unique case (req.sel)
                SEL_WIDX: begin
                    wptr <= req.data[IDX_W-1:0];
                    sub  <= '0;
                    mode <= MODE_WRITING;
                end
                SEL_RIDX: begin
                    rptr <= req.data[IDX_W-1:0];
                    sub  <= '0;
                    mode <= MODE_READING;
                end
                SEL_DATA: begin
                    if (last_slot) begin
                        sub  <= '0;
                        wptr <= wptr + 1'b1;
                    end else begin
                        stage_q[sub[0]] <= req.data[COMP_W-1:0];
                        sub <= sub + 1'b1;
                    end
                end
                default: ;
            endcase
        end else if (rd_go && (req.sel == SEL_DATA)) begin
            if (last_slot) begin
                sub  <= '0;
                rptr <= rptr + 1'b1;
            end else begin
                sub <= sub + 1'b1;
            end
        end
    end

endmodule

// File: rtl/dac_palette_store.sv
module dac_palette_store
    import dac_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  pal_entry_t       wentry,
    input  logic [IDX_W-1:0] cpu_idx,
    output pal_entry_t       cpu_entry,
    input  logic [IDX_W-1:0] pix_idx,
    output pal_entry_t       pix_entry
);

    pal_entry_t table_q [ENTRIES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) begin
                table_q[i] <= '0;
            end
        end else if (we) begin
            table_q[widx] <= wentry;
        end
    end

    assign cpu_entry = table_q[cpu_idx];
    assign pix_entry = table_q[pix_idx];

endmodule

// File: rtl/dac_pixel_expand.sv
module dac_pixel_expand
    import dac_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic [IDX_W-1:0]        idx_in,
    output logic [IDX_W-1:0]        idx_q,
    input  pal_entry_t              entry,
    output logic [N_COMP*OUT_W-1:0] rgb
);

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
        end else begin
            idx_q <= idx_in;
        end
    end

    for (genvar c = 0; c < N_COMP; c++) begin : g_comp
        assign rgb[(N_COMP-1-c)*OUT_W +: OUT_W] = widen(entry[c]);
    end

endmodule

// File: rtl/palette_dac_port.sv
module palette_dac_port
    import dac_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    bus_wr,
    input  logic                    bus_rd,
    input  logic [1:0]              bus_sel,
    input  logic [DATA_W-1:0]       bus_wdata,
    output logic [DATA_W-1:0]       bus_rdata,
    input  logic [IDX_W-1:0]        pix_idx,
    output logic [N_COMP*OUT_W-1:0] pix_rgb
);

    bus_req_t          req;
    logic [IDX_W-1:0]  wptr;
    logic [IDX_W-1:0]  rptr;
    logic [SUB_W-1:0]  sub;
    dac_mode_e         mode;
    logic              commit;
    logic [IDX_W-1:0]  commit_idx;
    pal_entry_t        commit_entry;
    pal_entry_t        cpu_entry;
    pal_entry_t        pix_entry;
    logic [IDX_W-1:0]  pix_idx_q;
    logic [COMP_W-1:0] cpu_comp;
    logic [DATA_W-1:0] rdata_q;

    assign req = '{wr: bus_wr, rd: bus_rd, sel: port_sel_e'(bus_sel), data: bus_wdata};

    dac_index_ctrl u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .req          (req),
        .wptr         (wptr),
        .rptr         (rptr),
        .sub          (sub),
        .mode         (mode),
        .commit       (commit),
        .commit_idx   (commit_idx),
        .commit_entry (commit_entry)
    );

    dac_palette_store u_store (
        .clk       (clk),
        .rst       (rst),
        .we        (commit),
        .widx      (commit_idx),
        .wentry    (commit_entry),
        .cpu_idx   (rptr),
        .cpu_entry (cpu_entry),
        .pix_idx   (pix_idx_q),
        .pix_entry (pix_entry)
    );

    dac_pixel_expand u_pix (
        .clk    (clk),
        .rst    (rst),
        .idx_in (pix_idx),
        .idx_q  (pix_idx_q),
        .entry  (pix_entry),
        .rgb    (pix_rgb)
    );

    always_comb begin
        unique case (sub)
            2'd0:    cpu_comp = cpu_entry[0];
            2'd1:    cpu_comp = cpu_entry[1];
            default: cpu_comp = cpu_entry[2];
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (req.rd && !req.wr) begin
            unique case (req.sel)
                SEL_RIDX: rdata_q <= DATA_W'(mode);
                SEL_DATA: rdata_q <= DATA_W'(cpu_comp);
                default:  rdata_q <= '0;
            endcase
        end
    end

    assign bus_rdata = rdata_q;

endmodule

// File: rtl/dac_port_checker.sv
module dac_port_checker (
    input logic       clk,
    input logic       rst,
    input logic       bus_wr,
    input logic       bus_rd,
    input logic [1:0] bus_sel,
    input logic [7:0] bus_wdata,
    input logic [7:0] wptr,
    input logic [7:0] rptr,
    input logic [1:0] sub,
    input logic [1:0] mode
);

    // R1
    widx_load_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_sel == 2'd0) |=> (wptr == $past(bus_wdata) && sub == 2'd0 && mode == 2'd0));

    // R2
    ridx_load_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_sel == 2'd1) |=> (rptr == $past(bus_wdata) && sub == 2'd0 && mode == 2'd3));

    // R3
    commit_adv_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_sel == 2'd2 && sub == 2'd2) |=> (wptr == 8'($past(wptr) + 8'd1) && sub == 2'd0));

    // R5
    sub_range_chk: assert property (@(posedge clk) disable iff (rst) sub != 2'd3);

    // R6
    mode_value_chk: assert property (@(posedge clk) disable iff (rst) (mode == 2'd0 || mode == 2'd3));

    // R10
    wr_beats_rd_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_rd && bus_sel == 2'd2) |=> $stable(rptr));

    // R13
    idle_sel_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_sel == 2'd3) |=> ($stable(wptr) && $stable(rptr) && $stable(sub) && $stable(mode)));

endmodule

bind palette_dac_port dac_port_checker chk_i (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_sel   (bus_sel),
    .bus_wdata (bus_wdata),
    .wptr      (wptr),
    .rptr      (rptr),
    .sub       (sub),
    .mode      (mode)
);

// File: tb/palette_dac_port_tb.sv
module palette_dac_port_tb_top;

    typedef struct {
        logic [23:0] val;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [1:0]  bus_sel = 2'd0;
    logic [7:0]  bus_wdata = 8'd0;
    logic [7:0]  bus_rdata;
    logic [7:0]  pix_idx = 8'd0;
    logic [23:0] pix_rgb;
    logic        px_req = 1'b0;
    logic        rd_seen = 1'b0;
    logic        px_seen = 1'b0;

    int n_vec = 0;
    int n_bad = 0;

    exp_t rd_q[$];
    exp_t px_q[$];

    // reference state derived from the requirements
    logic [5:0] m_pal [256][3];
    logic [7:0] m_wp, m_rp, m_last;
    logic [1:0] m_sub, m_mode;
    logic [5:0] m_stage [2];

    always #5 clk = ~clk;

    palette_dac_port dut_i (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_sel   (bus_sel),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pix_idx   (pix_idx),
        .pix_rgb   (pix_rgb)
    );

    always @(posedge clk) begin
        rd_seen <= bus_rd;
        px_seen <= px_req;
    end

    function automatic logic [7:0] wid(input logic [5:0] v);
        return {v, v[0], v[0]};
    endfunction

    function automatic logic [23:0] rgb_of(input logic [7:0] i);
        return {wid(m_pal[i][0]), wid(m_pal[i][1]), wid(m_pal[i][2])};
    endfunction

    task automatic compare(input logic [23:0] act, input logic [23:0] exp, input string tag);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (rd_seen) begin
                exp_t e;
                if (rd_q.size() == 0) begin
                    n_vec++; n_bad++;
                    $display("FAIL scoreboard: read result with empty queue, actual %h expected none", bus_rdata);
                end else begin
                    e = rd_q.pop_front();
                    compare({16'd0, bus_rdata}, e.val, e.tag);
                end
            end
            if (px_seen) begin
                exp_t e;
                if (px_q.size() == 0) begin
                    n_vec++; n_bad++;
                    $display("FAIL scoreboard: pixel result with empty queue, actual %h expected none", pix_rgb);
                end else begin
                    e = px_q.pop_front();
                    compare(pix_rgb, e.val, e.tag);
                end
            end
        end
    end

    // driver: one cycle, pushes expectations, advances the reference state
    task automatic step(input logic wr, input logic rd, input logic [1:0] sel,
                        input logic [7:0] d, input logic px, input logic [7:0] pidx,
                        input string tag);
        exp_t e;
        e.tag = tag;
        if (rd) begin
            if (wr) e.val = {16'd0, m_last};
            else if (sel == 2'd1) e.val = {22'd0, m_mode};
            else if (sel == 2'd2) e.val = {18'd0, m_pal[m_rp][m_sub]};
            else e.val = 24'd0;
            m_last = e.val[7:0];
            rd_q.push_back(e);
        end
        if (wr) begin
            case (sel)
                2'd0: begin m_wp = d; m_sub = 0; m_mode = 0; end
                2'd1: begin m_rp = d; m_sub = 0; m_mode = 3; end
                2'd2: begin
                    if (m_sub == 2) begin
                        m_pal[m_wp][0] = m_stage[0];
                        m_pal[m_wp][1] = m_stage[1];
                        m_pal[m_wp][2] = d[5:0];
                        m_wp = m_wp + 8'd1;
                        m_sub = 0;
                    end else begin
                        m_stage[m_sub[0]] = d[5:0];
                        m_sub = m_sub + 2'd1;
                    end
                end
                default: ;
            endcase
        end else if (rd && sel == 2'd2) begin
            if (m_sub == 2) begin m_sub = 0; m_rp = m_rp + 8'd1; end
            else m_sub = m_sub + 2'd1;
        end
        if (px) begin
            e.val = rgb_of(pidx);
            px_q.push_back(e);
        end
        bus_wr = wr; bus_rd = rd; bus_sel = sel; bus_wdata = d;
        px_req = px; pix_idx = pidx;
        @(posedge clk);
        #1;
        bus_wr = 1'b0; bus_rd = 1'b0; px_req = 1'b0;
    endtask

    task automatic wr_b(input logic [1:0] sel, input logic [7:0] d, input string tag);
        step(1'b1, 1'b0, sel, d, 1'b0, pix_idx, tag);
    endtask

    task automatic rd_b(input logic [1:0] sel, input string tag);
        step(1'b0, 1'b1, sel, 8'd0, 1'b0, pix_idx, tag);
    endtask

    task automatic look(input logic [7:0] i, input string tag);
        step(1'b0, 1'b0, 2'd0, 8'd0, 1'b1, i, tag);
    endtask

    initial begin
        #(200000 * 10);
        n_vec++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++)
            for (int c = 0; c < 3; c++) m_pal[i][c] = 6'd0;
        m_wp = 0; m_rp = 0; m_sub = 0; m_mode = 0; m_last = 0;
        m_stage[0] = 0; m_stage[1] = 0;

        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        compare({16'd0, bus_rdata}, 24'd0, "R11 rdata after reset");
        compare(pix_rgb, 24'd0, "R11 pixel after reset");
        @(posedge clk); #1;
        rd_b(2'd1, "R11 mode after reset");

        // R1 R3 R7: write entry 5 with an oversize blue
        wr_b(2'd0, 8'd5, "R1");
        rd_b(2'd1, "R6 mode writing");
        wr_b(2'd2, 8'h11, "R3");
        wr_b(2'd2, 8'h22, "R3");
        look(8'd5, "R3 entry unchanged before third byte");
        // R12: commit and lookup of the same entry on one edge
        step(1'b1, 1'b0, 2'd2, 8'hFF, 1'b1, 8'd5, "R12 commit visible to lookup");

        // R2 R4 R7: read back
        wr_b(2'd1, 8'd5, "R2");
        rd_b(2'd1, "R6 mode reading");
        rd_b(2'd2, "R4 red");
        rd_b(2'd2, "R4 green");
        rd_b(2'd2, "R7 blue masked");
        rd_b(2'd2, "R4 pointer advanced");
        rd_b(2'd0, "R6 select 0 reads zero");
        rd_b(2'd3, "R6 select 3 reads zero");

        // R8: wrap across 255
        wr_b(2'd0, 8'd255, "R1");
        wr_b(2'd2, 8'h3F, "R8"); wr_b(2'd2, 8'h00, "R8"); wr_b(2'd2, 8'h15, "R8");
        wr_b(2'd2, 8'h2A, "R8"); wr_b(2'd2, 8'h01, "R8"); wr_b(2'd2, 8'h3E, "R8");
        look(8'd0, "R8 write pointer wrapped");
        look(8'd255, "R9 expansion of 3F/00/15");
        wr_b(2'd1, 8'd255, "R2");
        for (int k = 0; k < 6; k++) rd_b(2'd2, "R8 read pointer wrap");

        // R5: a read between written bytes uses up a component slot
        wr_b(2'd1, 8'd0, "R2");
        wr_b(2'd0, 8'd10, "R1");
        wr_b(2'd2, 8'h07, "R5");
        rd_b(2'd2, "R5 read takes slot 1");
        wr_b(2'd2, 8'h09, "R5 commit with stale slot");
        look(8'd10, "R5 shared counter result");

        // R10: write and read together
        wr_b(2'd1, 8'd10, "R2");
        rd_b(2'd2, "R4");
        step(1'b1, 1'b1, 2'd2, 8'h30, 1'b0, pix_idx, "R10 rdata held");
        rd_b(2'd2, "R10 read pointer not moved");

        // R13: select 3 write changes nothing
        wr_b(2'd1, 8'd5, "R2");
        wr_b(2'd3, 8'hA5, "R13");
        rd_b(2'd1, "R13 mode kept");
        rd_b(2'd2, "R13 counter kept");

        // R12: CPU read and pixel lookup of different entries together
        step(1'b0, 1'b1, 2'd2, 8'd0, 1'b1, 8'd255, "R12 concurrent read and lookup");
        look(8'd3, "R9 untouched entry");

        repeat (3) @(posedge clk);
        if (rd_q.size() != 0 || px_q.size() != 0) begin
            n_vec++; n_bad++;
            $display("FAIL scoreboard: actual %0d pending expected 0", rd_q.size() + px_q.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule